// File: doc/BRIEF.md
# SMBus Master SCL/SDA Timing Generator

This block produces the clock line of an SMBus or I2C-style master and decides the exact system-clock cycle in which the outgoing data bit may appear on SDA. The low and high phases of SCL are measured in strobes from an external tick source, such as a timer overflow. The high phase is nominally twice as long as the low phase. Both lines are open-drain: the block either pulls a line low or releases it.

After the block releases SCL, it reads the line back through a two-flop synchronizer. The high phase does not begin until the line is seen high, so a slow device that holds SCL low simply lengthens the bit.

During the low phase the next data bit is placed on SDA a fixed number of system clocks after SCL was pulled low. This gives the hold margin. SCL is released only after a minimum setup interval has passed. A configuration bit selects between the standard margins and the extended margins. A one-cycle strobe marks each falling edge that closes a completed bit.

Top module: `smb_clkgen`

## Requirements
- R1: While `en` is low, and from reset, in the following cycle `scl_low` is 0 (SCL released), `sda_o` is 1 (SDA released) and `bit_done` is 0. A `scl_low` of 1 pulls SCL low; an `sda_o` of 0 pulls SDA low.
- R2: Each low phase lasts until at least LOW_TICKS (default 2) `tick` strobes have been seen in cycles where `scl_low` is 1. In standard mode, with ticks at least 4 cycles apart, it is exactly LOW_TICKS.
- R3: The high phase counts 2*LOW_TICKS ticks after the synchronized SCL reads high. With ticks at least 4 cycles apart, the ticks seen while SCL is released and high total 2*LOW_TICKS or 2*LOW_TICKS+1.
- R4: While another device holds SCL low after release, the block does not pull SCL low again, and none of that time counts towards the high phase.
- R5: With `ext_hold`=0, SDA changes exactly 3 system clocks after `scl_low` rises. The setup time is therefore the low time minus 3 clocks.
- R6: With `ext_hold`=1, SDA changes exactly 12 system clocks after `scl_low` rises.
- R7: With `ext_hold`=1, SCL is released no sooner than 11 system clocks after the SDA update point.
- R8: `bit_done` is a one-cycle pulse. It is raised in the same cycle that `scl_low` rises at the end of a high phase. It is never raised for the first low phase after enable.
- R9: The level of `sda_o` when SCL rises equals `tx_bit` as sampled at the SDA update point of that low phase.
- R10: Dropping `en` in the middle of a bit releases both lines in the next cycle. Re-enabling starts a fresh low phase, with its hold counted from the new falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Master enable; low forces idle |
| tick | input | 1 | Clock-source strobe, one cycle wide |
| scl_in | input | 1 | Raw SCL line level |
| ext_hold | input | 1 | Selects extended SDA setup/hold margins |
| tx_bit | input | 1 | Next data bit to place on SDA |
| scl_low | output | 1 | 1 pulls SCL low |
| sda_o | output | 1 | SDA drive; 1 releases the line |
| bit_done | output | 1 | One-cycle strobe at the SCL fall that ends a bit |

## Verification
The properties assume that `tick` is a single-cycle pulse and that `ext_hold` changes only while `en` is low. They also assume that other devices pull SCL low only after the block has released it, never during a high phase that is under way. The bench keeps within these limits. It produces a tick every fourth clock and changes the margin bit only between disabled runs. Its stretching slave holds the line low for eight cycles after each release, and only when a test turns it on. `tx_bit` is changed one cycle after each `bit_done`, which is well ahead of the earliest SDA update point.

// File: rtl/smb_clkgen.sv
module smb_clkgen #(
  parameter int LOW_TICKS = 2,
  parameter int HOLD_STD  = 3,
  parameter int SETUP_STD = 1,
  parameter int HOLD_EXT  = 12,
  parameter int SETUP_EXT = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic scl_in,
  input  logic ext_hold,
  input  logic tx_bit,
  output logic scl_low,
  output logic sda_o,
  output logic bit_done
);
  localparam int HIGH_TICKS = 2 * LOW_TICKS;
  localparam int TW = $clog2(HIGH_TICKS + 1);
  localparam int CW = $clog2(HOLD_EXT + SETUP_EXT + 1);
  localparam logic [TW-1:0] LOW_N  = TW'(LOW_TICKS);
  localparam logic [TW-1:0] HIGH_N = TW'(HIGH_TICKS);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_WAIT, S_HIGH} st_t;

  st_t           st;
  logic [1:0]    sync;
  logic [TW-1:0] tcnt;
  logic [CW-1:0] ccnt;
  logic [CW-1:0] hold_at;
  logic [CW-1:0] rel_at;
  logic          low_done;
  logic          high_done;

  assign hold_at   = ext_hold ? CW'(HOLD_EXT - 1) : CW'(HOLD_STD - 1);
  assign rel_at    = ext_hold ? CW'(HOLD_EXT + SETUP_EXT - 1) : CW'(HOLD_STD + SETUP_STD - 1);
  assign low_done  = (tcnt == LOW_N) && (ccnt >= rel_at);
  assign high_done = tcnt == HIGH_N;
  assign scl_low   = st == S_LOW;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sync     <= 2'b00;
      tcnt     <= '0;
      ccnt     <= '0;
      sda_o    <= 1'b1;
      bit_done <= 1'b0;
    end else begin
      sync     <= {sync[0], scl_in};
      bit_done <= 1'b0;
      if (!en) begin
        st    <= S_IDLE;
        tcnt  <= '0;
        ccnt  <= '0;
        sda_o <= 1'b1;
      end else begin
        case (st)
          S_IDLE: begin
            st   <= S_LOW;
            tcnt <= '0;
            ccnt <= '0;
          end
          S_LOW: begin
            if (ccnt < rel_at) ccnt <= ccnt + 1'b1;
            if (tick && tcnt != LOW_N) tcnt <= tcnt + 1'b1;
            if (ccnt == hold_at) sda_o <= tx_bit;
            if (low_done) begin
              st   <= S_WAIT;
              tcnt <= '0;
            end
          end
          S_WAIT: begin
            tcnt <= '0;
            if (sync[1]) st <= S_HIGH;
          end
          S_HIGH: begin
            if (tick && !high_done) tcnt <= tcnt + 1'b1;
            if (high_done) begin
              st       <= S_LOW;
              tcnt     <= '0;
              ccnt     <= '0;
              bit_done <= 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_clkgen_chk.sv
module smb_clkgen_chk #(
  parameter int LOW_TICKS = 2,
  parameter int HOLD_STD  = 3,
  parameter int HOLD_EXT  = 12,
  parameter int SETUP_EXT = 11
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic tick,
  input logic scl_in,
  input logic ext_hold,
  input logic scl_low,
  input logic sda_o,
  input logic bit_done
);
  logic [5:0] lowc;
  logic [5:0] lticks;
  logic [5:0] hticks;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lowc   <= '0;
      lticks <= '0;
      hticks <= '0;
    end else begin
      if (!scl_low) lowc <= '0;
      else if (lowc != 6'h3f) lowc <= lowc + 1'b1;
      if (!scl_low) lticks <= '0;
      else if (tick && lticks != 6'h3f) lticks <= lticks + 1'b1;
      if (scl_low) hticks <= '0;
      else if (tick && scl_in && hticks != 6'h3f) hticks <= hticks + 1'b1;
    end
  end

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_low && sda_o && !bit_done));

  a_r2_low_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_low) && en && $past(en)) |-> lticks >= 6'(LOW_TICKS));

  a_r3_high_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |-> hticks >= 6'(2 * LOW_TICKS));

  a_r5_std_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_low && $past(scl_low) && sda_o != $past(sda_o) && !ext_hold) |-> lowc == 6'(HOLD_STD));

  a_r6_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_low && $past(scl_low) && sda_o != $past(sda_o) && ext_hold) |-> lowc == 6'(HOLD_EXT));

  a_r7_ext_setup: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_low) && en && $past(en) && ext_hold) |-> lowc >= 6'(HOLD_EXT + SETUP_EXT));

  a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |-> $rose(scl_low));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |=> !bit_done);
endmodule

bind smb_clkgen smb_clkgen_chk #(
  .LOW_TICKS(LOW_TICKS),
  .HOLD_STD(HOLD_STD),
  .HOLD_EXT(HOLD_EXT),
  .SETUP_EXT(SETUP_EXT)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .en(en),
  .tick(tick),
  .scl_in(scl_in),
  .ext_hold(ext_hold),
  .scl_low(scl_low),
  .sda_o(sda_o),
  .bit_done(bit_done)
);

// File: tb/test_smb_clkgen.sv
module test_smb_clkgen;
  localparam int LOW_T  = 2;
  localparam int HIGH_T = 2 * LOW_T;
  localparam int STRETCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic tick = 1'b0;
  logic ext_hold = 1'b0;
  logic tx_bit = 1'b1;
  logic stretch_on = 1'b0;
  logic [STRETCH-1:0] hist = '0;
  logic [1:0] tc = 2'd0;
  logic scl_low, sda_o, bit_done, scl_line;

  int n_cmp = 0;
  int n_bad = 0;
  logic exp_q[$];

  always #10 clk = ~clk;

  assign scl_line = ~scl_low & ~(stretch_on & (|hist));

  smb_clkgen #(.LOW_TICKS(LOW_T)) i_smb_clkgen (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .scl_in(scl_line),
    .ext_hold(ext_hold), .tx_bit(tx_bit),
    .scl_low(scl_low), .sda_o(sda_o), .bit_done(bit_done)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      tc <= 2'd0; tick <= 1'b0; hist <= '0;
    end else begin
      tc <= tc + 2'd1;
      tick <= (tc == 2'd3);
      hist <= {hist[STRETCH-2:0], scl_low};
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int lc = 0, lt = 0, ht = 0, sc = 0;
  bit ran = 0;
  logic p_low = 1'b0, p_sda = 1'b1, p_line = 1'b1;

  always @(negedge clk) begin
    if (rst_n && en) begin
      if (scl_low && !p_low) begin
        if (ran) begin
          chk(ht >= HIGH_T && ht <= HIGH_T + 1, "R3 high ticks", ht, HIGH_T);
          if (stretch_on) chk(sc == STRETCH, "R4 stretched cycles", sc, STRETCH);
        end
        chk(bit_done == ran, "R8 done at fall", bit_done, ran);
        lc = 0; lt = 0; ran = 1;
      end else if (scl_low) begin
        lc++;
        chk(!bit_done, "R8 done width", bit_done, 0);
      end
      if (scl_low && tick) lt++;
      if (scl_low && p_low && sda_o != p_sda) begin
        if (ext_hold) chk(lc == 12, "R6 ext hold", lc, 12);
        else chk(lc == 3, "R5 std hold", lc, 3);
      end
      if (!scl_low && p_low) begin
        if (ext_hold) begin
          chk(lt >= LOW_T, "R2 low ticks", lt, LOW_T);
          chk(lc + 1 - 12 >= 11, "R7 ext setup", lc + 1 - 12, 11);
        end else chk(lt == LOW_T, "R2 low ticks", lt, LOW_T);
        ht = 0; sc = 0;
      end
      if (!scl_low) begin
        if (scl_line && tick) ht++;
        if (!scl_line) sc++;
      end
      if (scl_line && !p_line && ran) begin
        if (exp_q.size() == 0) chk(0, "R9 unexpected bit", sda_o, -1);
        else begin
          logic e;
          e = exp_q.pop_front();
          chk(sda_o == e, "R9 sda at rise", sda_o, e);
        end
      end
    end else begin
      lc = 0; lt = 0; ht = 0; sc = 0; ran = 0;
    end
    p_low = scl_low; p_sda = sda_o; p_line = scl_line;
  end

  task automatic wait_done;
    do @(negedge clk); while (!bit_done);
  endtask

  task automatic run_bits(input logic [7:0] pat, input int n);
    @(posedge clk);
    tx_bit <= pat[n-1]; exp_q.push_back(pat[n-1]); en <= 1'b1;
    for (int i = n - 2; i >= 0; i--) begin
      wait_done;
      @(posedge clk);
      tx_bit <= pat[i]; exp_q.push_back(pat[i]);
    end
    wait_done;
    @(posedge clk);
    en <= 1'b0;
    repeat (2) @(negedge clk);
    chk(!scl_low && sda_o && !bit_done, "R1 released after run", {scl_low, sda_o, bit_done}, 3'b010);
    chk(exp_q.size() == 0, "R9 all bits seen", exp_q.size(), 0);
  endtask

  task automatic tests;
    repeat (4) @(posedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    chk(!scl_low && sda_o && !bit_done, "R1 reset state", {scl_low, sda_o, bit_done}, 3'b010);
    run_bits(8'b1011_0010, 8);
    ext_hold <= 1'b1;
    run_bits(8'b0110_1001, 8);
    ext_hold <= 1'b0;
    @(posedge clk);
    tx_bit <= 1'b0; exp_q.push_back(1'b0); en <= 1'b1;
    repeat (6) @(posedge clk);
    en <= 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!scl_low && sda_o, "R10 abort releases", {scl_low, sda_o}, 2'b01);
    exp_q.delete();
    run_bits(8'b0000_0101, 3);
    stretch_on <= 1'b1;
    run_bits(8'b0010_1101, 6);
    ext_hold <= 1'b1;
    run_bits(8'b0000_1010, 4);
    stretch_on <= 1'b0;
    ext_hold <= 1'b0;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    bit wd;
    wd = 0;
    fork
      tests;
      begin
        repeat (150000) @(posedge clk);
        wd = 1;
      end
    join_any
    disable fork;
    if (wd) chk(0, "watchdog", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule